// File: doc/BRIEF.md
# Per-Row Activation Counter Tracker

This block keeps one activation counter for each row of a small modelled DRAM bank. Each row-activate command carries a row address. When the command is accepted, the block increments that row's counter by one and watches one selected bit of the counter, the threshold bit. If the increment changes the value of that bit, in either direction, the row is flagged for mitigation. A flagged row address is offered at once to a downstream service queue over a valid/ready push interface.

A counter is never cleared after a flag. A row is therefore flagged again every time its count advances by one threshold-sized stride. Reset clears every counter. A debug port reads any row's counter combinationally.

When a flag meets a queue that is not ready, the row is held pending and activates are back-pressured until the push completes. No flag is lost.

Top module: `row_act_tracker`

## Requirements
- R1: After reset every counter reads 0 on the debug port, `act_ready_o` is 1 and `svc_valid_o` is 0.
- R2: An activate is accepted when `act_valid_i` and `act_ready_o` are both high at a rising clock edge. It increments only the counter of `act_row_i`, by exactly 1. The debug port `dbg_cnt_o` shows the counter of `dbg_row_i` from the next cycle on.
- R3: An accepted activate whose increment changes the threshold bit (default bit 10) from 0 to 1 raises `svc_valid_o` in the same cycle, with `svc_row_o` equal to `act_row_i`.
- R4: An increment that changes the threshold bit from 1 to 0 also flags the row in the same cycle.
- R5: An increment that leaves the threshold bit unchanged raises no flag. A flag does not clear the counter: for example, 0x03FF becomes 0x0400 and keeps counting from there.
- R6: Counters wrap modulo 2^16. The increment 0xFFFF to 0x0000 clears the threshold bit and flags the row.
- R7: If `svc_ready_i` is low when a flag occurs, the row is held pending. `svc_valid_o` stays high with `svc_row_o` unchanged until a cycle in which `svc_ready_i` is high.
- R8: While a flag is pending, `act_ready_o` is 0 and any activate presented is ignored. No counter changes.
- R9: When `svc_ready_i` is high with a flag pending, the push completes at that edge, and `act_ready_o` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears all counters |
| act_valid_i | input | 1 | Row-activate command valid |
| act_row_i | input | 6 | Row address of the activate |
| act_ready_o | output | 1 | Activate can be accepted this cycle |
| svc_valid_o | output | 1 | Row offered to the service queue |
| svc_row_o | output | 6 | Row address offered to the service queue |
| svc_ready_i | input | 1 | Service queue accepts a row this cycle |
| dbg_row_i | input | 6 | Row selected for debug read |
| dbg_cnt_o | output | 16 | Counter of the selected row |

## Verification
A wrong counter value shows up on the debug port in the cycle after the bad increment. It also shows up in the toggle pattern: a missed or doubled increment shifts a flag by one activate, so an exact count of activates between flags exposes it at the next threshold crossing. Holding faults show within one cycle of a stall, as a dropped `svc_valid_o`, a changed `svc_row_o`, or a counter that moves while `act_ready_o` is low. A wrap fault appears at the 65,536th activate of a row.

// File: rtl/rat_pkg.sv
package rat_pkg;
  parameter int unsigned DEF_ROWS    = 64;
  parameter int unsigned DEF_CNT_W   = 16;
  parameter int unsigned DEF_THR_BIT = 10;
endpackage

// File: rtl/rat_cnt_bank.sv
module rat_cnt_bank #(
  parameter int unsigned ROWS  = rat_pkg::DEF_ROWS,
  parameter int unsigned CNT_W = rat_pkg::DEF_CNT_W,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROW_W-1:0] rd_row_i,
  output logic [CNT_W-1:0] rd_cnt_o,
  input  logic [ROW_W-1:0] dbg_row_i,
  output logic [CNT_W-1:0] dbg_cnt_o,
  input  logic             wr_en_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [CNT_W-1:0] wr_cnt_i
);
  logic [CNT_W-1:0] cnt_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '{default: '0};
    else if (wr_en_i) cnt_q[wr_row_i] <= wr_cnt_i;
  end

  assign rd_cnt_o  = cnt_q[rd_row_i];
  assign dbg_cnt_o = cnt_q[dbg_row_i];

  // R2: a write always moves the addressed counter
  a_r2_counter_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cnt_q[$past(wr_row_i)] != $past(cnt_q[wr_row_i]));
endmodule

// File: rtl/rat_stride_det.sv
module rat_stride_det #(
  parameter int unsigned CNT_W   = rat_pkg::DEF_CNT_W,
  parameter int unsigned THR_BIT = rat_pkg::DEF_THR_BIT
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] nxt_o,
  output logic             hit_o
);
  // modulo 2^CNT_W increment; wrap needs no special case
  assign nxt_o = cnt_i + CNT_W'(1);
  assign hit_o = cnt_i[THR_BIT] ^ nxt_o[THR_BIT];
endmodule

// File: rtl/rat_push_hold.sv
module rat_push_hold #(
  parameter int unsigned ROW_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             svc_ready_i,
  output logic             svc_valid_o,
  output logic [ROW_W-1:0] svc_row_o,
  output logic             busy_o
);
  logic             pend_q;
  logic [ROW_W-1:0] pend_row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_row_q <= '0;
    end else if (pend_q) begin
      if (svc_ready_i) pend_q <= 1'b0;
    end else if (req_i && !svc_ready_i) begin
      pend_q     <= 1'b1;
      pend_row_q <= row_i;
    end
  end

  assign svc_valid_o = pend_q || req_i;
  assign svc_row_o   = pend_q ? pend_row_q : row_i;
  assign busy_o      = pend_q;

  a_r7_hold_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_valid_o && !svc_ready_i |=> svc_valid_o && $stable(svc_row_o));
  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && svc_ready_i |=> !busy_o);
endmodule

// File: rtl/row_act_tracker.sv
module row_act_tracker #(
  parameter int unsigned ROWS    = rat_pkg::DEF_ROWS,
  parameter int unsigned CNT_W   = rat_pkg::DEF_CNT_W,
  parameter int unsigned THR_BIT = rat_pkg::DEF_THR_BIT,
  localparam int unsigned ROW_W  = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_valid_i,
  input  logic [ROW_W-1:0] act_row_i,
  output logic             act_ready_o,
  output logic             svc_valid_o,
  output logic [ROW_W-1:0] svc_row_o,
  input  logic             svc_ready_i,
  input  logic [ROW_W-1:0] dbg_row_i,
  output logic [CNT_W-1:0] dbg_cnt_o
);
  logic             accept, hit, busy;
  logic [CNT_W-1:0] cur_cnt, nxt_cnt;

  assign act_ready_o = !busy;
  assign accept      = act_valid_i && act_ready_o;

  rat_cnt_bank #(.ROWS(ROWS), .CNT_W(CNT_W)) u_bank (
    .clk_i, .rst_ni,
    .rd_row_i (act_row_i), .rd_cnt_o (cur_cnt),
    .dbg_row_i, .dbg_cnt_o,
    .wr_en_i (accept), .wr_row_i (act_row_i), .wr_cnt_i (nxt_cnt)
  );

  rat_stride_det #(.CNT_W(CNT_W), .THR_BIT(THR_BIT)) u_det (
    .cnt_i (cur_cnt), .nxt_o (nxt_cnt), .hit_o (hit)
  );

  rat_push_hold #(.ROW_W(ROW_W)) u_push (
    .clk_i, .rst_ni,
    .req_i (accept && hit), .row_i (act_row_i),
    .svc_ready_i, .svc_valid_o, .svc_row_o, .busy_o (busy)
  );

  // R3: with nothing pending, an offer only comes from a live activate
  a_r3_offer_from_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_valid_o && act_ready_o |-> act_valid_i && svc_row_o == act_row_i);
  // R8: back-pressure persists while the queue refuses an offer
  a_r8_stall_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_valid_o && !svc_ready_i |=> !act_ready_o);
endmodule

// File: tb/row_act_tracker_bench.sv
module row_act_tracker_bench;
  logic        clk = 0, rst_n = 0;
  logic        act_valid = 0, svc_ready = 1;
  logic [5:0]  act_row = '0, dbg_row = '0;
  logic        act_ready, svc_valid;
  logic [5:0]  svc_row;
  logic [15:0] dbg_cnt;
  int vectors = 0, fails = 0;

  always #10 clk = ~clk;

  row_act_tracker u_row_act_tracker (
    .clk_i(clk), .rst_ni(rst_n), .act_valid_i(act_valid), .act_row_i(act_row),
    .act_ready_o(act_ready), .svc_valid_o(svc_valid), .svc_row_o(svc_row),
    .svc_ready_i(svc_ready), .dbg_row_i(dbg_row), .dbg_cnt_o(dbg_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [5:0] row, output logic [15:0] val);
    dbg_row = row; #1; val = dbg_cnt;
  endtask

  // one activate, returns whether the row was offered this cycle
  task automatic step(input logic [5:0] row, output logic flag, output logic [5:0] frow);
    @(negedge clk);
    act_valid = 1; act_row = row;
    #1; flag = svc_valid && act_ready; frow = svc_row;
    @(posedge clk); #1 act_valid = 0;
  endtask

  task automatic run(input logic [5:0] row, input int n, output int flags, output logic last);
    logic f; logic [5:0] fr;
    flags = 0; last = 0;
    for (int i = 0; i < n; i++) begin
      step(row, f, fr);
      if (f) begin flags++; if (fr !== row) chk("R3 flag row", fr, row); end
      last = f;
    end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    @(negedge clk);
    chk("R1 act_ready", act_ready, 1);
    chk("R1 svc_valid", svc_valid, 0);
    peek(0, v);  chk("R1 cnt row0", v, 0);
    peek(63, v); chk("R1 cnt row63", v, 0);
  endtask

  task automatic t_incr;
    int n; logic l; logic [15:0] v;
    run(3, 3, n, l); chk("R5 no flag small count", n, 0);
    run(4, 1, n, l);
    peek(3, v); chk("R2 row3 count", v, 3);
    peek(4, v); chk("R2 row4 count", v, 1);
    peek(2, v); chk("R2 row2 untouched", v, 0);
  endtask

  task automatic t_rise_fall;
    int n; logic l; logic [15:0] v;
    run(10, 1023, n, l); chk("R5 no flag below stride", n, 0);
    run(10, 1, n, l);    chk("R3 rising flag", n, 1);
    peek(10, v);         chk("R5 not cleared after flag", v, 16'h0400);
    run(10, 1024, n, l); chk("R4 one flag per stride", n, 1);
    chk("R4 falling flag on last", l, 1);
    peek(10, v);         chk("R5 count continues", v, 16'h0800);
  endtask

  task automatic t_wrap;
    int n; logic l; logic [15:0] v;
    run(20, 65535, n, l); chk("R5 flags over full range", n, 63);
    peek(20, v);          chk("R6 count at max", v, 16'hFFFF);
    run(20, 1, n, l);     chk("R6 wrap flag", n, 1);
    peek(20, v);          chk("R6 wrapped to zero", v, 0);
  endtask

  task automatic t_stall;
    int n; logic l; logic [15:0] v;
    run(7, 1023, n, l);
    @(negedge clk);
    svc_ready = 0; act_valid = 1; act_row = 7;
    #1;
    chk("R3 offer under stall", svc_valid, 1);
    chk("R3 offer row", svc_row, 7);
    @(negedge clk);
    act_row = 7; act_valid = 1;
    #1;
    chk("R8 ready low while pending", act_ready, 0);
    chk("R7 valid held", svc_valid, 1);
    chk("R7 row held", svc_row, 7);
    @(negedge clk);
    act_valid = 0;
    peek(7, v); chk("R8 ignored activate", v, 16'h0400);
    chk("R7 still held", svc_valid, 1);
    svc_ready = 1; #1;
    chk("R9 offer with ready", svc_valid, 1);
    @(negedge clk); #1;
    chk("R9 ready restored", act_ready, 1);
    chk("R9 offer gone", svc_valid, 0);
    peek(7, v); chk("R9 count unchanged", v, 16'h0400);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_incr;
    t_rise_fall;
    t_wrap;
    t_stall;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule